// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Register

This block is the digital front end of a serial-input digital-to-analog converter. A serial bit stream is clocked into an N-bit shift register, most significant bit first, on rising edges of a serial clock. A separate N-bit holding register supplies the code that drives the converter. Because the two registers are separate, a new word can be shifted in without disturbing the code that the converter is using.

An active-low load strobe controls the transfer. It acts on the level, not on an edge: while the strobe is low, the holding register follows the shift register, and the serial clock is gated off. An active-low clear forces the holding register to zero and overrides the strobe. If clear is released while the strobe is still low, the shift-register contents pass straight through. All four serial-side inputs are asynchronous to the system clock. They are oversampled through two-flop synchronizers, and serial-clock rising edges are detected in the system clock domain. A one-cycle pulse marks every change of the output code.

Top module: `serdac_front`

## Requirements
- R1: On each rising edge of `ser_clk` seen while `load_n` is high, `ser_data` is shifted into the shift register at bit 0 and earlier bits move up one place. The first bit received therefore ends up as the MSB of an N-bit word.
- R2: While `load_n` is low, `ser_clk` edges leave the shift register unchanged.
- R3: While `load_n` is low and `clear_n` is high, `dac_code` follows the shift register, within four system clock cycles of any input change.
- R4: While `load_n` and `clear_n` are both high, `dac_code` holds its value.
- R5: While `clear_n` is low, `dac_code` is zero whatever `load_n` is. Shifting continues normally during this time.
- R6: If `clear_n` rises while `load_n` is high, `dac_code` stays zero until the next load.
- R7: If `clear_n` rises while `load_n` is low, `dac_code` takes the current shift-register contents.
- R8: If more than N bits are shifted in before a load, only the last N bits received are kept.
- R9: After reset, `dac_code` is zero, the shift register is zero and `code_upd` is low.
- R10: `code_upd` is high for exactly one cycle each time `dac_code` changes, in the same cycle as the new value, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_clk | input | 1 | Serial clock; its rising edges shift the data in |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low level-sensitive transfer strobe |
| clear_n | input | 1 | Active-low clear of the output code |
| dac_code | output | N | Code presented to the converter |
| code_upd | output | 1 | One-cycle pulse on each change of `dac_code` |

## Verification
Any fault in the shift register stays hidden until the next load. It then appears in `dac_code` within four cycles of the strobe falling, as a wrong bit or a word shifted by one place. A fault in the holding register shows at once, either as a code change that no load or clear explains or as a pulse on `code_upd` that does not match a change of `dac_code`. Clear ordering faults appear only on the clear release edge. For this reason the bench releases clear with the strobe held high and also with it held low.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    // Action taken by the holding register on the next system clock.
    typedef enum logic [1:0] {
        HOLD_KEEP   = 2'd0,
        HOLD_FOLLOW = 2'd1,
        HOLD_ZERO   = 2'd2
    } hold_act_e;

    // Synchronizer depth shared by all asynchronous inputs.
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int unsigned W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
    parameter int unsigned N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         sdat_s,
    input  logic         ld_s,
    output logic [N-1:0] sr
);
    typedef struct packed {
        logic         sclk_prev;
        logic [N-1:0] word;
    } shift_t;

    shift_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d           = st_q;
        // Edge tracking runs all the time, so that a rising edge that
        // falls inside a load window is used up and not replayed later.
        st_d.sclk_prev = sclk_s;
        rise           = sclk_s & ~st_q.sclk_prev;
        if (rise && ld_s) begin
            st_d.word = {st_q.word[N-2:0], sdat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr = st_q.word;
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold
    import dacfe_pkg::*;
#(
    parameter int unsigned N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_s,
    input  logic         clr_s,
    input  logic [N-1:0] sr,
    output logic [N-1:0] code,
    output logic         upd
);
    typedef struct packed {
        logic [N-1:0] code;
        logic         upd;
    } hold_t;

    hold_t     st_d, st_q;
    hold_act_e act;

    always_comb begin
        // Clear wins over load; load low makes the register transparent.
        if (!clr_s)     act = HOLD_ZERO;
        else if (!ld_s) act = HOLD_FOLLOW;
        else            act = HOLD_KEEP;

        st_d = st_q;
        unique case (act)
            HOLD_ZERO:   st_d.code = '0;
            HOLD_FOLLOW: st_d.code = sr;
            default:     st_d.code = st_q.code;
        endcase
        st_d.upd = (st_d.code != st_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign upd  = st_q.upd;
endmodule

// File: rtl/serdac_front.sv
module serdac_front #(
    parameter int unsigned N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         load_n,
    input  logic         clear_n,
    output logic [N-1:0] dac_code,
    output logic         code_upd
);
    // Bundle order: {clear_n, load_n, ser_data, ser_clk}
    localparam int unsigned NSIG = 4;
    localparam logic [NSIG-1:0] IDLE_LVL = 4'b1100;

    logic [NSIG-1:0] raw, synced;
    logic [N-1:0]    sr_q;

    assign raw = {clear_n, load_n, ser_data, ser_clk};

    dacfe_sync #(.W(NSIG), .RST_VAL(IDLE_LVL)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw),
        .q    (synced)
    );

    dacfe_shift #(.N(N)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(synced[0]),
        .sdat_s(synced[1]),
        .ld_s  (synced[2]),
        .sr    (sr_q)
    );

    dacfe_hold #(.N(N)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .ld_s (synced[2]),
        .clr_s(synced[3]),
        .sr   (sr_q),
        .code (dac_code),
        .upd  (code_upd)
    );
endmodule

// File: rtl/serdac_front_checker.sv
module serdac_front_checker #(
    parameter int unsigned N = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n,
    input logic         clear_n,
    input logic [N-1:0] dac_code,
    input logic         code_upd,
    input logic [N-1:0] sr
);
    // An input change reaches the registers three clock edges after it is sampled.
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear_n, 3) |-> dac_code == '0) else $error("clear"); // R5

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_n, 3) && $past(clear_n, 3)) |-> dac_code == $past(dac_code)) else $error("hold"); // R4

    AST_FOLLOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_n, 3) && $past(clear_n, 3)) |-> dac_code == $past(sr)) else $error("follow"); // R3

    AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_n, 3) |-> $stable(sr)) else $error("frozen"); // R2

    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |-> dac_code != $past(dac_code)) else $error("upd"); // R10

    AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !code_upd |-> $stable(dac_code)) else $error("silent"); // R10
endmodule

bind serdac_front serdac_front_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .clear_n (clear_n),
    .dac_code(dac_code),
    .code_upd(code_upd),
    .sr      (sr_q)
);

// File: tb/serdac_front_bench.sv
`timescale 1ns/1ps
module serdac_front_bench;
    localparam int unsigned N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_data = 1'b0;
    logic         load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [N-1:0] dac_code;
    logic         code_upd;

    int compared = 0;
    int mismatched = 0;
    int pulses = 0;
    int exp_pulses = 0;
    bit finished = 1'b0;

    logic [N-1:0] sr_m = '0;
    logic [N-1:0] dac_m = '0;

    always #5 clk = ~clk;

    serdac_front #(.N(N)) u_serdac_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code), .code_upd(code_upd)
    );

    always @(negedge clk) if (rst_n && code_upd) pulses++;

    function automatic logic [N-1:0] last_bits(input logic [31:0] w, input int len);
        // Bits are sent from bit len-1 down to bit 0; only the final N remain.
        return w[N-1:0];
    endfunction

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_apply();
        logic [N-1:0] nv;
        nv = dac_m;
        if (!clear_n)     nv = '0;
        else if (!load_n) nv = sr_m;
        if (nv != dac_m) exp_pulses++;
        dac_m = nv;
    endtask

    task automatic set_ctl(input logic ld, input logic cl);
        @(negedge clk);
        load_n = ld;
        clear_n = cl;
        model_apply();
        settle(6);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        settle(3);
        ser_clk = 1'b1;
        if (load_n) sr_m = {sr_m[N-2:0], b};
        model_apply();
        settle(3);
        ser_clk = 1'b0;
        settle(3);
    endtask

    task automatic send_word(input logic [31:0] w, input int len);
        for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic do_load(input string req);
        set_ctl(1'b0, clear_n);
        chk(req, dac_code, dac_m);
        set_ctl(1'b1, clear_n);
        chk(req, dac_code, dac_m);
        chk("R10 settled", {{(N-1){1'b0}}, code_upd}, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int len;
        void'($urandom(32'd20511));
        settle(4);
        rst_n = 1'b1;
        settle(4);
        // R9 reset state
        chk("R9 code", dac_code, '0);
        chk("R9 upd", {{(N-1){1'b0}}, code_upd}, '0);
        do_load("R9 shift reg zero");

        // R1 MSB first
        send_word(32'h800, N);
        chk("R4 hold before load", dac_code, '0);
        do_load("R1 msb first");
        send_word(32'h5A6, N);
        do_load("R1 pattern");
        chk("R1 model", dac_m, 12'h5A6);

        // R8 extra bits discarded
        send_word(32'hA5C3, 16);
        do_load("R8 last bits");
        chk("R8 expected", dac_m, last_bits(32'hA5C3, 16));

        // R2 clock edges during load low are ignored; R3 follows
        send_word(32'h3C1, N);
        set_ctl(1'b0, 1'b1);
        chk("R3 follow", dac_code, 12'h3C1);
        send_word(32'hFFF, 5);
        chk("R2 frozen", dac_code, 12'h3C1);
        set_ctl(1'b1, 1'b1);
        send_word(32'h0, 1);
        do_load("R2 no replay");

        // R5 clear forces zero, shifting continues
        set_ctl(1'b1, 1'b0);
        chk("R5 zero", dac_code, '0);
        send_word(32'h9E7, N);
        set_ctl(1'b0, 1'b0);
        chk("R5 zero over load", dac_code, '0);
        // R7 release with load low passes shift contents
        set_ctl(1'b0, 1'b1);
        chk("R7 pass through", dac_code, 12'h9E7);
        set_ctl(1'b1, 1'b1);

        // R6 release with load high stays zero
        set_ctl(1'b1, 1'b0);
        set_ctl(1'b1, 1'b1);
        chk("R6 stays zero", dac_code, '0);
        do_load("R6 next load");

        // Random traffic
        for (int it = 0; it < 30; it++) begin
            w = $urandom;
            len = N + int'($urandom % 5);
            send_word(w, len);
            chk("R4 hold random", dac_code, dac_m);
            if ($urandom % 4 == 0) begin
                set_ctl(1'b1, 1'b0);
                chk("R5 random clear", dac_code, '0);
                set_ctl(1'b1, 1'b1);
            end
            do_load("R8 random");
            chk("R8 random word", dac_code, last_bits(w, len));
        end

        settle(4);
        compared++;
        if (pulses != exp_pulses) begin
            mismatched++;
            $display("FAIL R10 pulses: actual %0d expected %0d", pulses, exp_pulses);
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule